// File: doc/BRIEF.md
# Packed Shift and Precision-Reduce Unit

This block shifts packed 32-bit data in one of three ways, picked by an operation code. It can shift four signed byte lanes right arithmetically. It can shift two unsigned halfword lanes right logically. It can also reduce precision: two signed 32-bit words are each shifted right arithmetically, and the low half of each is packed into one 32-bit result. The byte mode and the word mode can round: when rounding is on, the last bit shifted out of a lane is added back into that lane.

The shift amount comes either from an immediate field or from the low bits of a register operand. Only as many bits are used as the lane width needs: three for bytes, four for halfwords and five for words. The datapath is combinational and ends in one output register with a synchronous active-low reset. A result therefore appears one clock after its inputs. Instruction decode and register-file access belong to the surrounding pipeline.

Top module: `pks_shift_unit`

## Requirements
- R1: A rising clock edge with `rst_n` low sets `res_q` to zero.
- R2: `res_q` shows the result for the inputs present at the previous rising clock edge, and it does not change between edges.
- R3: With `op_sel` = 0, each byte lane of `src_a` (bits 8k+7:8k) is treated as a signed value and shifted right arithmetically by the byte amount (amount bits 2:0). The result goes to the same lane.
- R4: With `round_en` high in the byte or word mode, a nonzero amount s and bit s-1 of the lane's input set, the shifted lane value is increased by one.
- R5: With `op_sel` = 1, each 16-bit lane of `src_a` is shifted right logically by amount bits 3:0, with zeros filling from the top. `round_en` has no effect in this mode.
- R6: With `op_sel` = 2, `src_a` and `src_b` are each shifted right arithmetically by amount bits 4:0, with rounding as in R4. Bits 15:0 of the shifted `src_a` go to `res_q[31:16]`, and bits 15:0 of the shifted `src_b` go to `res_q[15:0]`.
- R7: An amount of zero, counted in the bits the mode uses, passes the lanes through unchanged. No rounding is applied, whatever `round_en` is.
- R8: With `use_reg_amt` high the amount is taken from `amt_reg`; with it low, from `amt_imm`. Amount bits above those the mode uses are ignored.
- R9: `op_sel` = 3 gives a result of zero.
- R10: A rounding increment that overflows a lane wraps within that lane and leaves the neighbouring lane unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 2 | 0 byte arithmetic, 1 halfword logical, 2 precision reduce, 3 reserved |
| round_en | input | 1 | Enables rounding in the byte and word modes |
| use_reg_amt | input | 1 | Chooses the amount source: 1 register operand, 0 immediate |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 5 | Low bits of the register operand that holds the shift amount |
| src_a | input | 32 | Packed lanes, or the first word in reduce mode |
| src_b | input | 32 | Second word in reduce mode |
| res_q | output | 32 | Registered packed result |

## Verification
The clocked properties assume the inputs are stable and known at each rising edge. They also assume `op_sel` holds a defined two-bit code, since every property maps inputs sampled at one edge to `res_q` one edge later. The bench changes inputs only on the falling edge, so every value is settled a half period before it is captured. It drives each mode with every five-bit amount, with and without rounding, from both amount sources, on lanes at their signed extremes. Each result is compared with a behavioural model on the following falling edge.

// File: rtl/pks_pkg.sv
// Package for the packed shift unit.
// Holds the operation code, which the neighbouring decode logic must produce
// with the same values.
package pks_pkg;

    typedef enum logic [1:0] {
        PKS_BYTE_SRA    = 2'd0,
        PKS_HALF_SRL    = 2'd1,
        PKS_WORD_REDUCE = 2'd2,
        PKS_RESERVED    = 2'd3
    } pks_op_e;

endpackage

// File: rtl/pks_sra_lane.sv
// Arithmetic right shift of one signed lane, with optional rounding.
// Rounding adds the last bit shifted out, and only when the amount is nonzero.
// Only the low OUT_W bits of the rounded value are driven, so a rounding
// overflow wraps inside the lane.
// Assumes OUT_W <= W and that SW can count up to W-1.
module pks_sra_lane #(
    parameter int unsigned W     = 8,
    parameter int unsigned SW    = 3,
    parameter int unsigned OUT_W = 8
) (
    input  logic [W-1:0]     lane_in,
    input  logic [SW-1:0]    amt,
    input  logic             rnd,
    output logic [OUT_W-1:0] lane_out
);

    logic signed [W-1:0] shifted;
    logic                round_bit;

    // Shift, pick the rounding bit, then add it within the output width.
    always_comb begin
        shifted   = $signed(lane_in) >>> amt;
        round_bit = 1'b0;
        if (rnd && (amt != '0)) begin
            round_bit = lane_in[amt - 1'b1];
        end
        lane_out = OUT_W'(shifted) + OUT_W'(round_bit);
    end

endmodule

// File: rtl/pks_srl_lane.sv
// Logical right shift of one unsigned lane, with zeros filling from the top.
// Assumes SW can count up to W-1.
module pks_srl_lane #(
    parameter int unsigned W  = 16,
    parameter int unsigned SW = 4
) (
    input  logic [W-1:0]  lane_in,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  lane_out
);

    // Plain logical shift, no rounding.
    always_comb begin
        lane_out = lane_in >> amt;
    end

endmodule

// File: rtl/pks_shift_unit.sv
// Packed shift and precision-reduce unit.
// Builds all three lane groups side by side, picks one of them by operation
// code and registers the result, so results appear one clock later.
// Assumes DATA_W is a multiple of both BYTE_W and HALF_W, with HALF_W*2 == DATA_W
// for the reduce packing.
module pks_shift_unit
    import pks_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned HALF_W = 16,
    localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_sel,
    input  logic              round_en,
    input  logic              use_reg_amt,
    input  logic [AMT_W-1:0]  amt_imm,
    input  logic [AMT_W-1:0]  amt_reg,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] res_q
);

    localparam int unsigned N_BYTES  = DATA_W / BYTE_W;
    localparam int unsigned N_HALVES = DATA_W / HALF_W;
    localparam int unsigned BAMT_W   = $clog2(BYTE_W);
    localparam int unsigned HAMT_W   = $clog2(HALF_W);

    logic [AMT_W-1:0]  amt_eff;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] half_res;
    logic [DATA_W-1:0] reduce_res;
    logic [DATA_W-1:0] res_d;

    // Pick the amount source.
    always_comb begin
        amt_eff = use_reg_amt ? amt_reg : amt_imm;
    end

    // Byte lanes: signed arithmetic shift on the low amount bits.
    for (genvar gb = 0; gb < N_BYTES; gb++) begin : g_byte
        pks_sra_lane #(
            .W     (BYTE_W),
            .SW    (BAMT_W),
            .OUT_W (BYTE_W)
        ) i_lane (
            .lane_in  (src_a[gb*BYTE_W +: BYTE_W]),
            .amt      (amt_eff[BAMT_W-1:0]),
            .rnd      (round_en),
            .lane_out (byte_res[gb*BYTE_W +: BYTE_W])
        );
    end

    // Halfword lanes: unsigned logical shift.
    for (genvar gh = 0; gh < N_HALVES; gh++) begin : g_half
        pks_srl_lane #(
            .W  (HALF_W),
            .SW (HAMT_W)
        ) i_lane (
            .lane_in  (src_a[gh*HALF_W +: HALF_W]),
            .amt      (amt_eff[HAMT_W-1:0]),
            .lane_out (half_res[gh*HALF_W +: HALF_W])
        );
    end

    // Reduce: shift both whole words, keep the low half of each.
    pks_sra_lane #(
        .W     (DATA_W),
        .SW    (AMT_W),
        .OUT_W (HALF_W)
    ) i_reduce_hi (
        .lane_in  (src_a),
        .amt      (amt_eff),
        .rnd      (round_en),
        .lane_out (reduce_res[DATA_W-1:HALF_W])
    );

    pks_sra_lane #(
        .W     (DATA_W),
        .SW    (AMT_W),
        .OUT_W (HALF_W)
    ) i_reduce_lo (
        .lane_in  (src_b),
        .amt      (amt_eff),
        .rnd      (round_en),
        .lane_out (reduce_res[HALF_W-1:0])
    );

    // Choose the result by operation code; the reserved code gives zero.
    always_comb begin
        unique case (pks_op_e'(op_sel))
            PKS_BYTE_SRA:    res_d = byte_res;
            PKS_HALF_SRL:    res_d = half_res;
            PKS_WORD_REDUCE: res_d = reduce_res;
            default:         res_d = '0;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

endmodule

// File: rtl/pks_shift_unit_chk.sv
// Checker for pks_shift_unit, attached with bind.
// Relates the inputs sampled at one edge to res_q one edge later.
// Assumes the inputs are known at every rising edge.
module pks_shift_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned HALF_W = 16,
    localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_sel,
    input logic              round_en,
    input logic              use_reg_amt,
    input logic [AMT_W-1:0]  amt_imm,
    input logic [AMT_W-1:0]  amt_reg,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] res_q
);

    localparam int unsigned N_BYTES = DATA_W / BYTE_W;
    localparam int unsigned BAMT_W  = $clog2(BYTE_W);
    localparam int unsigned HAMT_W  = $clog2(HALF_W);

    logic [AMT_W-1:0]  amt_c;
    logic [DATA_W-1:0] byte_fill;
    logic [DATA_W-1:0] word_fill;

    // Amount as the checker sees it.
    always_comb begin
        amt_c = use_reg_amt ? amt_reg : amt_imm;
    end

    // Each byte lane filled with its own sign bit.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_fill
        assign byte_fill[k*BYTE_W +: BYTE_W] = {BYTE_W{src_a[k*BYTE_W + BYTE_W - 1]}};
    end

    // Each half filled with the sign of its source word.
    assign word_fill = {{HALF_W{src_a[DATA_W-1]}}, {HALF_W{src_b[DATA_W-1]}}};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0));

    p_zero_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 2'd0 && amt_c[BAMT_W-1:0] == '0) ||
         (op_sel == 2'd1 && amt_c[HAMT_W-1:0] == '0))
        |=> (res_q == $past(src_a)));

    p_half_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd1 && amt_c[HAMT_W-1:0] != '0)
        |=> (!res_q[DATA_W-1] && !res_q[HALF_W-1]));

    p_byte_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd0 && !round_en && amt_c[BAMT_W-1:0] == BAMT_W'(BYTE_W - 1))
        |=> (res_q == $past(byte_fill)));

    p_reduce_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd2 && !round_en && amt_c == AMT_W'(DATA_W - 1))
        |=> (res_q == $past(word_fill)));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd3) |=> (res_q == '0));

endmodule

bind pks_shift_unit pks_shift_unit_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .HALF_W (HALF_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_sel      (op_sel),
    .round_en    (round_en),
    .use_reg_amt (use_reg_amt),
    .amt_imm     (amt_imm),
    .amt_reg     (amt_reg),
    .src_a       (src_a),
    .src_b       (src_b),
    .res_q       (res_q)
);

// File: tb/test_pks_shift_unit.sv
// Bench for pks_shift_unit. Inputs are driven on the falling edge. Each
// expected value is computed by a behavioural model and queued when its inputs
// are driven, then compared on the next falling edge.
module test_pks_shift_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_sel;
    logic        round_en;
    logic        use_reg_amt;
    logic [4:0]  amt_imm;
    logic [4:0]  amt_reg;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic [31:0] res_q;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pks_shift_unit i_pks_shift_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_sel      (op_sel),
        .round_en    (round_en),
        .use_reg_amt (use_reg_amt),
        .amt_imm     (amt_imm),
        .amt_reg     (amt_reg),
        .src_a       (src_a),
        .src_b       (src_b),
        .res_q       (res_q)
    );

    // Signed right shift of a w-bit value, rounding by the last bit shifted out.
    function automatic longint model_sra(longint v, int w, int s, bit rnd);
        longint x = v;
        longint r;
        if (x >= (64'sd1 <<< (w - 1))) x = x - (64'sd1 <<< w);
        r = x >>> s;
        if (rnd && s > 0 && (((x >>> (s - 1)) & 64'sd1) != 0)) r = r + 1;
        return r;
    endfunction

    function automatic logic [31:0] model(int op, bit rnd, int amt,
                                          logic [31:0] a, logic [31:0] b);
        logic [31:0] r = '0;
        longint t;
        case (op)
            0: for (int i = 0; i < 4; i++) begin
                   t = model_sra(longint'(a[8*i +: 8]), 8, amt % 8, rnd);
                   r[8*i +: 8] = t[7:0];
               end
            1: for (int i = 0; i < 2; i++) begin
                   r[16*i +: 16] = a[16*i +: 16] >> (amt % 16);
               end
            2: begin
                   t = model_sra(longint'(a), 32, amt % 32, rnd);
                   r[31:16] = t[15:0];
                   t = model_sra(longint'(b), 32, amt % 32, rnd);
                   r[15:0] = t[15:0];
               end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: res_q=%h expected=%h", tag, got, exp);
        end
    endtask

    // Compare the oldest pending result, then drive new inputs and queue their result.
    task automatic step(int op, bit rnd, bit usereg, int amt,
                        logic [31:0] a, logic [31:0] b, string tag);
        @(negedge clk);
        if (exp_q.size() > 0) begin
            last_exp = exp_q.pop_front();
            check(tag_q.pop_front(), res_q, last_exp);
        end
        op_sel      = 2'(op);
        round_en    = rnd;
        use_reg_amt = usereg;
        amt_imm     = usereg ? ~5'(amt) : 5'(amt);
        amt_reg     = usereg ? 5'(amt) : ~5'(amt);
        src_a       = a;
        src_b       = b;
        exp_q.push_back(model(op, rnd, amt, a, b));
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk);
        while (exp_q.size() > 0) begin
            last_exp = exp_q.pop_front();
            check(tag_q.pop_front(), res_q, last_exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: res_q=%h expected=finish", res_q);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats[4];
        string tag;
        pats[0] = 32'h807F_FF01;
        pats[1] = 32'h7F80_0180;
        pats[2] = 32'h8000_7FFF;
        pats[3] = 32'hA5C3_3C5A;

        // R1: reset clears the output even with live inputs.
        rst_n = 1'b0; op_sel = 2'd0; round_en = 1'b1; use_reg_amt = 1'b0;
        amt_imm = 5'd1; amt_reg = 5'd2; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", res_q, 32'h0);
        rst_n = 1'b1;

        // Sweep every mode, every amount, both rounding settings and both amount sources.
        for (int op = 0; op < 4; op++)
            for (int p = 0; p < 4; p++)
                for (int amt = 0; amt < 32; amt++)
                    for (int r = 0; r < 2; r++)
                        for (int u = 0; u < 2; u++) begin
                            if (op == 3) tag = "R9";
                            else if ((op == 0 && amt % 8 == 0) || (op == 1 && amt % 16 == 0) ||
                                     (op == 2 && amt == 0)) tag = "R7";
                            else if (u == 1) tag = "R8";
                            else if (r == 1 && op != 1) tag = "R4";
                            else if (op == 0) tag = "R3";
                            else if (op == 1) tag = "R5";
                            else tag = "R6";
                            step(op, r[0], u[0], amt, pats[p], {pats[p][15:0], ~pats[p][31:16]}, tag);
                        end
        flush();

        // R10: a rounding carry out of the upper half wraps and leaves the lower half alone.
        step(2, 1'b1, 1'b0, 1, 32'h0001_FFFF, 32'h0000_0000, "R10");
        step(2, 1'b1, 1'b0, 1, 32'h0001_FFFF, 32'h0001_FFFE, "R10");
        step(2, 1'b1, 1'b1, 4, 32'h000F_FFF8, 32'h000F_FFF8, "R10");
        flush();

        // R2: the output holds its value until the next rising edge.
        step(0, 1'b0, 1'b0, 1, 32'h8080_8080, 32'h0, "R2");
        step(1, 1'b0, 1'b0, 0, 32'h1234_5678, 32'h0, "R2");
        #1;
        check("R2", res_q, last_exp);
        flush();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule